// File: doc/BRIEF.md
# Half-Duplex Shared Bus Controller

This block arbitrates one 10-bit bidirectional data bus between a transmit path and a receive path. A transmit word is taken from the bus on a clock edge only when transmit enable is high and receive enable is low. The captured word is forwarded one cycle later as a flow-through stream toward the transmit filter pipeline. When receive enable is high, the block drives the receive-path word onto the bus through a registered output enable. With both enables low, the bus is released to high impedance. Both paths share one clock in this block.

When transmit enable falls after at least one capture, a trailing sequencer counts clock cycles. For 48 cycles it feeds zero words downstream in place of bus data, which flushes the filter pipeline. A drain flag rises after the 6th trailing cycle and a flush flag after the 48th. Raising transmit enable again during the window cancels the count, and capture resumes on that edge.

The transmit stream has no ready input, so no back-pressure can be applied. The downstream pipeline must take one word on every cycle in which `tx_valid` is high.

Top module: `hdx_bus_ctrl`

## Requirements
- R1: While `rst_n` is low, and at the first sample after reset, `tx_valid`, `tx_word`, `zero_fill`, `bus_oe`, `bus_out`, `buf_drained` and `flush_done` are all 0.
- R2: A clock edge that samples `tx_en`=1 and `rx_en`=0 makes `tx_valid`=1 and `tx_word` equal to the sampled `bus_in` from that edge onward, with `zero_fill`=0.
- R3: An edge that samples both `tx_en` and `rx_en` high performs no capture: `tx_valid` is 0 after it, and `bus_oe` is 1.
- R4: An edge that samples `rx_en`=1 sets `bus_oe`=1 and `bus_out` to the sampled `rx_data`.
- R5: An edge that samples `rx_en`=0 sets `bus_oe`=0 and `bus_out`=0, whatever the value of `tx_en`. The bus is in high impedance when both enables are low, and is an input while transmit captures.
- R6: Once a capture has happened since reset, each of the first 48 edges that sample `tx_en`=0 produces `tx_valid`=1, `tx_word`=0 and `zero_fill`=1, whatever `bus_in` carries.
- R7: `buf_drained` is 1 exactly when at least 6 consecutive trailing edges have been counted since the last edge that sampled `tx_en`=1.
- R8: `flush_done` becomes 1 after the 48th trailing edge, and stays 1 until an edge samples `tx_en`=1. After the 48th trailing edge, `tx_valid` is 0 while `tx_en` stays low.
- R9: An edge that samples `tx_en`=1 during the trailing window clears the count. `buf_drained` and `flush_done` are then 0, and the edge captures normally if `rx_en` is 0.
- R10: Before the first capture after reset, edges with `tx_en`=0 start no trailing window: `tx_valid`, `zero_fill` and both flags stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared transmit/receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable, wins over transmit |
| bus_in | input | 10 | Value seen on the shared bus pads |
| rx_data | input | 10 | Word from the receive path |
| bus_out | output | 10 | Word to drive onto the bus |
| bus_oe | output | 1 | Pad output enable, 1 drives the bus |
| tx_valid | output | 1 | Transmit stream word valid (no back-pressure) |
| tx_word | output | 10 | Transmit stream word toward the filters |
| zero_fill | output | 1 | Current transmit word is an inserted zero |
| buf_drained | output | 1 | Input buffers have drained after disable |
| flush_done | output | 1 | Filter pipeline has been zero-flushed |

## Verification
The assertions assume that the enables and data inputs change only between clock edges. They also assume the downstream pipeline accepts every valid word, because the stream has no ready signal. The bench drives all inputs on the falling edge, so every rising edge sees settled values. It places enable transitions at chosen trailing counts: before the 6th edge, between the drain and flush points, and past the flush point. It also injects noise on `bus_in` during the flush window, to show that the data there has no effect.

// File: rtl/hdx_pkg.sv
package hdx_pkg;
  localparam int HDX_DATA_W    = 10;
  localparam int HDX_DRAIN_CYC = 6;
  localparam int HDX_FLUSH_CYC = 48;
endpackage

// File: rtl/hdx_bus_drive.sv
module hdx_bus_drive #(
  parameter int DATA_W = hdx_pkg::HDX_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic [DATA_W-1:0] rx_data,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_oe  <= 1'b0;
      bus_out <= '0;
    end else begin
      bus_oe  <= rx_en;
      bus_out <= rx_en ? rx_data : '0;
    end
  end

  // R5
  tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!bus_oe && bus_out == '0));

  // R4
  rx_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en |=> (bus_oe && bus_out == $past(rx_data)));
endmodule

// File: rtl/hdx_trail_seq.sv
module hdx_trail_seq #(
  parameter int DRAIN_CYC = hdx_pkg::HDX_DRAIN_CYC,
  parameter int FLUSH_CYC = hdx_pkg::HDX_FLUSH_CYC
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic capture,
  output logic step,
  output logic zero_fill,
  output logic buf_drained,
  output logic flush_done
);
  localparam int CNT_W = $clog2(FLUSH_CYC + 1);
  localparam logic [CNT_W-1:0] FLUSH_V = CNT_W'(FLUSH_CYC);
  localparam logic [CNT_W-1:0] DRAIN_V = CNT_W'(DRAIN_CYC);

  logic             seen_q;
  logic [CNT_W-1:0] cnt_q;

  assign step = !tx_en && seen_q && (cnt_q < FLUSH_V);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q    <= 1'b0;
      cnt_q     <= '0;
      zero_fill <= 1'b0;
    end else begin
      if (capture) seen_q <= 1'b1;
      if (tx_en)     cnt_q <= '0;
      else if (step) cnt_q <= cnt_q + 1'b1;
      zero_fill <= step;
    end
  end

  assign buf_drained = seen_q && (cnt_q >= DRAIN_V);
  assign flush_done  = seen_q && (cnt_q == FLUSH_V);

  // R8
  flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_done && !tx_en) |=> flush_done);

  // R9
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |=> (!buf_drained && !flush_done));
endmodule

// File: rtl/hdx_tx_capture.sv
module hdx_tx_capture #(
  parameter int DATA_W = hdx_pkg::HDX_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              step,
  input  logic [DATA_W-1:0] bus_in,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_word
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_word  <= '0;
    end else begin
      tx_valid <= capture || step;
      tx_word  <= capture ? bus_in : '0;
    end
  end

  // R2
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (tx_valid && tx_word == $past(bus_in)));
endmodule

// File: rtl/hdx_bus_ctrl.sv
module hdx_bus_ctrl #(
  parameter int DATA_W    = hdx_pkg::HDX_DATA_W,
  parameter int DRAIN_CYC = hdx_pkg::HDX_DRAIN_CYC,
  parameter int FLUSH_CYC = hdx_pkg::HDX_FLUSH_CYC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic [DATA_W-1:0] bus_in,
  input  logic [DATA_W-1:0] rx_data,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_word,
  output logic              zero_fill,
  output logic              buf_drained,
  output logic              flush_done
);
  logic capture;
  logic step;

  assign capture = tx_en && !rx_en;

  hdx_bus_drive #(.DATA_W(DATA_W)) u_drive (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_data(rx_data),
    .bus_out(bus_out), .bus_oe(bus_oe)
  );

  hdx_trail_seq #(.DRAIN_CYC(DRAIN_CYC), .FLUSH_CYC(FLUSH_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .capture(capture),
    .step(step), .zero_fill(zero_fill),
    .buf_drained(buf_drained), .flush_done(flush_done)
  );

  hdx_tx_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .capture(capture), .step(step),
    .bus_in(bus_in), .tx_valid(tx_valid), .tx_word(tx_word)
  );

  // R6
  zero_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_fill |-> (tx_valid && tx_word == '0));

  // R3
  rx_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && rx_en) |=> (bus_oe && (!tx_valid || zero_fill) == !tx_valid));

  // R7
  drain_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> buf_drained);
endmodule

// File: tb/hdx_bus_ctrl_bench.sv
module hdx_bus_ctrl_bench;
  localparam int W = 10;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, rx_en = 1'b0;
  logic [W-1:0] bus_in = '0, rx_data = '0;
  logic [W-1:0] bus_out, tx_word;
  logic bus_oe, tx_valid, zero_fill, buf_drained, flush_done;

  int tests = 0, fails = 0, cycles = 0;

  always #2 clk = ~clk;

  hdx_bus_ctrl u_hdx_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
    .bus_in(bus_in), .rx_data(rx_data), .bus_out(bus_out), .bus_oe(bus_oe),
    .tx_valid(tx_valid), .tx_word(tx_word), .zero_fill(zero_fill),
    .buf_drained(buf_drained), .flush_done(flush_done)
  );

  // behavioural reference
  bit m_seen = 0, m_v = 0, m_z = 0, m_oe = 0;
  int m_trail = 0;
  int m_w = 0, m_out = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_seen = 0; m_trail = 0; m_v = 0; m_z = 0; m_oe = 0; m_w = 0; m_out = 0;
    end else begin
      m_oe  = rx_en;
      m_out = rx_en ? int'(rx_data) : 0;
      if (tx_en) begin
        m_trail = 0;
        m_z = 0;
        if (!rx_en) begin m_v = 1; m_w = int'(bus_in); m_seen = 1; end
        else begin m_v = 0; m_w = 0; end
      end else if (m_seen && m_trail < 48) begin
        m_trail++; m_v = 1; m_w = 0; m_z = 1;
      end else begin
        m_v = 0; m_w = 0; m_z = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(tx_valid == m_v, "R2 tx_valid", int'(tx_valid), int'(m_v));
      chk(int'(tx_word) == m_w, "R2/R6 tx_word", int'(tx_word), m_w);
      chk(zero_fill == m_z, "R6 zero_fill", int'(zero_fill), int'(m_z));
      chk(bus_oe == m_oe, "R4/R5 bus_oe", int'(bus_oe), int'(m_oe));
      chk(int'(bus_out) == m_out, "R4 bus_out", int'(bus_out), m_out);
      chk(buf_drained == (m_seen && m_trail >= 6), "R7 buf_drained",
          int'(buf_drained), int'(m_seen && m_trail >= 6));
      chk(flush_done == (m_seen && m_trail == 48), "R8 flush_done",
          int'(flush_done), int'(m_seen && m_trail == 48));
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cycles);
      finish_run();
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic burst(input int n, input int base);
    tx_en = 1; rx_en = 0;
    for (int i = 0; i < n; i++) begin
      bus_in = W'(base + 37 * i);
      @(negedge clk);
    end
  endtask

  initial begin
    tick(3);
    chk(!tx_valid && !bus_oe && !flush_done && !buf_drained && !zero_fill && bus_out == 0,
        "R1 reset", int'(tx_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!tx_valid && !bus_oe && tx_word == 0, "R1 after release", int'(tx_valid), 0);
    // R10: idle with noise, no prior capture
    for (int i = 0; i < 8; i++) begin bus_in = W'(i * 91); @(negedge clk); end
    chk(!tx_valid && !zero_fill && !buf_drained, "R10 no window", int'(tx_valid), 0);
    // R2 capture burst
    burst(5, 17);
    chk(tx_valid && !zero_fill, "R2 capture", int'(tx_valid), 1);
    // trailing with noise on bus (R6)
    tx_en = 0;
    for (int i = 0; i < 5; i++) begin bus_in = W'(1023 - i); @(negedge clk); end
    chk(buf_drained == 0, "R7 before 6th", int'(buf_drained), 0);
    chk(tx_word == 0 && zero_fill, "R6 zero word", int'(tx_word), 0);
    @(negedge clk);
    chk(buf_drained == 1, "R7 at 6th", int'(buf_drained), 1);
    tick(41);
    chk(flush_done == 0, "R8 before 48th", int'(flush_done), 0);
    @(negedge clk);
    chk(flush_done == 1, "R8 at 48th", int'(flush_done), 1);
    tick(3);
    chk(flush_done && !tx_valid, "R8 hold", int'(tx_valid), 0);
    // R3 both enables high
    tx_en = 1; rx_en = 1;
    for (int i = 0; i < 4; i++) begin rx_data = W'(300 + i); bus_in = W'(5 + i); @(negedge clk); end
    chk(!tx_valid && bus_oe && bus_out == W'(303), "R3 rx wins", int'(bus_out), 303);
    // R5 both low -> high impedance
    tx_en = 0; rx_en = 0;
    @(negedge clk);
    chk(!bus_oe && bus_out == 0, "R5 release", int'(bus_oe), 0);
    // R9 abort in window after drain point
    burst(3, 200);
    tx_en = 0;
    tick(10);
    chk(buf_drained, "R7 mid window", int'(buf_drained), 1);
    burst(2, 500);
    chk(!buf_drained && tx_valid && int'(tx_word) == 537, "R9 abort", int'(tx_word), 537);
    // abort before drain point, then full flush while receiving
    tx_en = 0; tick(3);
    burst(1, 77);
    tx_en = 0; rx_en = 1;
    for (int i = 0; i < 50; i++) begin rx_data = W'(i * 13); @(negedge clk); end
    chk(flush_done && bus_oe, "R8 flush during rx", int'(flush_done), 1);
    rx_en = 0;
    tick(4);
    chk(!bus_oe, "R5 final", int'(bus_oe), 0);
    finish_run();
  end
endmodule